// File: doc/BRIEF.md
# Message Reception Timestamp Unit

This block keeps a free-running 16-bit time base for a message controller. It records that time into a per-message register at the moment a message arrives. The time base advances once per prescale period. The period is a power-of-two multiple of the bus clock, picked by a 2-bit select input. The host can read and overwrite the counter at any moment, but it cannot stop it.

When the counter rolls over from its highest value to zero, a sticky overflow flag is set. The host inspects the flag and clears it through the same byte-wide register port. Comparing two stamps of one message, with this flag in view, gives the age and repetition rate of that message. Only the first eight message slots have stamp registers. Receive events for higher indices leave every stamp untouched.

Top module: `rx_stamp_unit`

## Requirements
- R1: After reset the counter, the overflow flag, all eight stamp registers, `host_rdata` and `host_rvalid` are zero.
- R2: With no host write, the counter changes only by stepping up by exactly one at the end of each prescale period, with no enable or stop control.
- R3: `ps_sel` sets the prescale period: 0 gives 32 bus clocks, 1 gives 64, 2 gives 128 and 3 gives 256.
- R4: A host write to address 0 replaces the counter's low byte and a write to address 1 replaces its high byte; the other byte keeps its value.
- R5: A step from 0xFFFF to 0x0000 sets the overflow flag, read as bit 0 of address 2 (bits 7:1 read zero).
- R6: The overflow flag stays set until the host writes address 2 with bit 0 at 1; a write with bit 0 at 0 leaves it set, and a wrap in the same cycle as a clear leaves it set.
- R7: A host counter write in a cycle where a step is due wins: the written value is loaded without the step, and a write never sets the overflow flag.
- R8: A change of `ps_sel` restarts the prescale count, so the next step comes one full new period after the clock edge that sees the change.
- R9: A receive event with index 0 to 7 loads the counter value into that index's stamp, readable as low byte at address 16+2k and high byte at 17+2k.
- R10: If a receive event and a counter step fall in the same cycle, the stamp takes the value from before the step.
- R11: Receive events with index 8 to 15 change no stamp register.
- R12: A stamp keeps its value until an event with its own index arrives.
- R13: A read request on `host_rd` returns the addressed byte on `host_rdata` with `host_rvalid` high one clock later, holding the value the register had at the requesting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps_sel | input | 2 | Prescale period select |
| rx_evt | input | 1 | One-cycle pulse for a received message |
| rx_idx | input | 4 | Index of the received message |
| host_rd | input | 1 | Host read request |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 5 | Host register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after request |

## Verification
Three pairs of functions can share a cycle. A host counter write can fall on a prescale step, a status clear can fall on a counter wrap, and a receive capture can fall on a step. The bench tracks the bus clock edge count from reset. It places the write, the clear or the receive pulse on exactly the edge where the prescaler's step is due. It then reads the counter, the status bit and the stamp back through the register port. The expected outcomes are that the written value is loaded without the step, that the flag ends set, and that the stamp holds the pre-step count.

// File: rtl/rxts_pkg.sv
package rxts_pkg;
   localparam int BYTE_W = 8;

   // Address of the status byte relative to the timer bytes
   function automatic int stat_addr(input int timer_bytes);
      return timer_bytes;
   endfunction

   // Base address of the stamp window: upper half of the address space
   function automatic int stamp_base(input int addr_w);
      return 2 ** (addr_w - 1);
   endfunction
endpackage

// File: rtl/rxts_prescaler.sv
module rxts_prescaler #(
   parameter int SEL_W          = 2,
   parameter int BASE_LOG2      = 5,
   parameter bit RESTART_ON_SEL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int CNT_W = BASE_LOG2 + (2 ** SEL_W) - 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;
   logic             restart;

   // term = period - 1, a mask of the low BASE_LOG2+sel bits
   always_comb term = ~({CNT_W{1'b1}} << (BASE_LOG2 + int'(sel)));

   generate
      if (RESTART_ON_SEL) begin : g_restart
         logic [SEL_W-1:0] sel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sel_q <= '0;
            else        sel_q <= sel;
         end
         assign restart = (sel != sel_q);
      end else begin : g_free
         assign restart = 1'b0;
      end
   endgenerate

   assign tick = !restart && (cnt_q >= term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (restart || tick) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/rxts_counter.sv
module rxts_counter #(
   parameter int W  = 16,
   parameter int NB = W / rxts_pkg::BYTE_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick,
   input  logic [NB-1:0]             byte_we,
   input  logic [rxts_pkg::BYTE_W-1:0] wdata,
   output logic [W-1:0]              value,
   output logic                      wrap
);
   import rxts_pkg::*;

   logic [W-1:0] value_q;
   logic [W-1:0] value_d;
   logic         any_we;

   assign any_we = |byte_we;

   always_comb begin
      value_d = value_q;
      if (any_we) begin
         for (int b = 0; b < NB; b++) begin
            if (byte_we[b]) value_d[b*BYTE_W +: BYTE_W] = wdata;
         end
      end else if (tick) begin
         value_d = value_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) value_q <= '0;
      else        value_q <= value_d;
   end

   assign value = value_q;
   assign wrap  = tick && !any_we && (&value_q);
endmodule

// File: rtl/rxts_capture_bank.sv
module rxts_capture_bank #(
   parameter int SLOTS = 8,
   parameter int IDX_W = 4,
   parameter int W     = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rx_evt,
   input  logic [IDX_W-1:0]          rx_idx,
   input  logic [W-1:0]              cap_val,
   output logic [SLOTS-1:0][W-1:0]   stamps
);
   generate
      for (genvar k = 0; k < SLOTS; k++) begin : g_slot
         logic         hit;
         logic [W-1:0] stamp_q;
         assign hit = rx_evt && (rx_idx == IDX_W'(k));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   stamp_q <= '0;
            else if (hit) stamp_q <= cap_val;
         end
         assign stamps[k] = stamp_q;
      end
   endgenerate
endmodule

// File: rtl/rx_stamp_unit.sv
module rx_stamp_unit #(
   parameter int TIMER_W      = 16,
   parameter int SLOTS        = 8,
   parameter int IDX_W        = 4,
   parameter int PS_SEL_W     = 2,
   parameter int PS_BASE_LOG2 = 5,
   parameter int ADDR_W       = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PS_SEL_W-1:0] ps_sel,
   input  logic                rx_evt,
   input  logic [IDX_W-1:0]    rx_idx,
   input  logic                host_rd,
   input  logic                host_wr,
   input  logic [ADDR_W-1:0]   host_addr,
   input  logic [7:0]          host_wdata,
   output logic [7:0]          host_rdata,
   output logic                host_rvalid
);
   import rxts_pkg::*;

   localparam int TB         = TIMER_W / BYTE_W;
   localparam int STAT_ADDR  = stat_addr(TB);
   localparam int STAMP_BASE = stamp_base(ADDR_W);

   generate
      if (TIMER_W % BYTE_W != 0 || TB < 1)
         $error("TIMER_W must be a whole number of bytes");
      if (SLOTS < 1 || SLOTS > 2 ** IDX_W)
         $error("SLOTS must fit the receive index width");
      if (SLOTS * TB > STAMP_BASE)
         $error("stamp window exceeds the address space");
      if (STAT_ADDR >= STAMP_BASE)
         $error("status address collides with stamp window");
   endgenerate

   logic                        tick;
   logic                        wrap;
   logic [TB-1:0]               byte_we;
   logic [TIMER_W-1:0]          timer_q;
   logic [SLOTS-1:0][TIMER_W-1:0] stamps_q;
   logic                        ovf_q;
   logic                        ovf_clr;
   logic [BYTE_W-1:0]           rd_mux;

   rxts_prescaler #(
      .SEL_W(PS_SEL_W), .BASE_LOG2(PS_BASE_LOG2), .RESTART_ON_SEL(1'b1)
   ) u_presc (
      .clk(clk), .rst_n(rst_n), .sel(ps_sel), .tick(tick)
   );

   generate
      for (genvar b = 0; b < TB; b++) begin : g_we
         assign byte_we[b] = host_wr && (host_addr == ADDR_W'(b));
      end
   endgenerate

   rxts_counter #(.W(TIMER_W), .NB(TB)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .byte_we(byte_we),
      .wdata(host_wdata), .value(timer_q), .wrap(wrap)
   );

   rxts_capture_bank #(.SLOTS(SLOTS), .IDX_W(IDX_W), .W(TIMER_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .rx_idx(rx_idx),
      .cap_val(timer_q), .stamps(stamps_q)
   );

   assign ovf_clr = host_wr && (host_addr == ADDR_W'(STAT_ADDR)) && host_wdata[0];

   // A wrap outranks a clear landing on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_q <= 1'b0;
      else if (wrap)    ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
   end

   always_comb begin
      rd_mux = '0;
      for (int b = 0; b < TB; b++) begin
         if (host_addr == ADDR_W'(b)) rd_mux = timer_q[b*BYTE_W +: BYTE_W];
      end
      if (host_addr == ADDR_W'(STAT_ADDR)) rd_mux = {{(BYTE_W-1){1'b0}}, ovf_q};
      for (int k = 0; k < SLOTS; k++) begin
         for (int b = 0; b < TB; b++) begin
            if (host_addr == ADDR_W'(STAMP_BASE + k*TB + b))
               rd_mux = stamps_q[k][b*BYTE_W +: BYTE_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata  <= '0;
         host_rvalid <= 1'b0;
      end else begin
         host_rvalid <= host_rd;
         if (host_rd) host_rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/rxts_chk.sv
module rxts_chk #(
   parameter int TIMER_W = 16,
   parameter int SLOTS   = 8,
   parameter int IDX_W   = 4,
   parameter int ADDR_W  = 5
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          host_rd,
   input logic                          host_wr,
   input logic [ADDR_W-1:0]             host_addr,
   input logic [7:0]                    host_wdata,
   input logic                          host_rvalid,
   input logic                          rx_evt,
   input logic [IDX_W-1:0]              rx_idx,
   input logic [TIMER_W-1:0]            timer,
   input logic [SLOTS-1:0][TIMER_W-1:0] stamps,
   input logic                          ovf
);
   localparam int TB        = TIMER_W / 8;
   localparam int STAT_ADDR = TB;

   logic tmr_write;
   logic clr_write;
   assign tmr_write = host_wr && (int'(host_addr) < TB);
   assign clr_write = host_wr && (int'(host_addr) == STAT_ADDR) && host_wdata[0];

   // R2
   step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tmr_write) |-> (timer == $past(timer) || timer == $past(timer) + 1'b1));

   // R5
   wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(tmr_write) && (&$past(timer)) && timer == '0) |-> ovf);

   // R6
   sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ovf) && !$past(clr_write)) |-> ovf);

   // R7
   no_write_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tmr_write) && !$past(ovf)) |-> !ovf);

   // R13
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid == $past(host_rd));

   generate
      for (genvar k = 0; k < SLOTS; k++) begin : g_slot_chk
         // R9
         stamp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rx_evt) && $past(rx_idx) == IDX_W'(k)) |-> stamps[k] == $past(timer));
         // R12
         stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !($past(rx_evt) && $past(rx_idx) == IDX_W'(k)) |-> $stable(stamps[k]));
      end
   endgenerate
endmodule

bind rx_stamp_unit rxts_chk #(
   .TIMER_W(TIMER_W), .SLOTS(SLOTS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
   .host_addr(host_addr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
   .rx_evt(rx_evt), .rx_idx(rx_idx), .timer(timer_q), .stamps(stamps_q), .ovf(ovf_q)
);

// File: tb/tb_rx_stamp_unit.sv
module tb_rx_stamp_unit;
   localparam logic [4:0] A_TLO = 5'd0, A_THI = 5'd1, A_STAT = 5'd2, A_ST = 5'd16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ps_sel = 2'd0;
   logic       rx_evt = 1'b0;
   logic [3:0] rx_idx = '0;
   logic       host_rd = 1'b0, host_wr = 1'b0;
   logic [4:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       host_rvalid;

   int checks = 0, failures = 0;
   int unsigned ecount = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;
   always @(posedge clk) if (rst_n) ecount <= ecount + 1;

   rx_stamp_unit dut (
      .clk(clk), .rst_n(rst_n), .ps_sel(ps_sel), .rx_evt(rx_evt), .rx_idx(rx_idx),
      .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
   );

   // Monitor: pops one expected byte per returned read
   always @(negedge clk) begin
      logic [7:0] e;
      string t;
      if (rst_n && host_rvalid) begin
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R13 unexpected read data actual=%h expected=none", host_rdata);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (host_rdata !== e) begin
               failures++;
               $display("FAIL %s actual=%h expected=%h", t, host_rdata, e);
            end
         end
      end
   end

   task automatic at_edge(input int unsigned k);
      while (ecount < k - 1) @(negedge clk);
   endtask

   task automatic rd(input int unsigned k, input logic [4:0] a, input logic [7:0] e, input string t);
      at_edge(k);
      host_rd = 1'b1; host_addr = a;
      exp_q.push_back(e); tag_q.push_back(t);
      @(posedge clk); @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic wr(input int unsigned k, input logic [4:0] a, input logic [7:0] d);
      at_edge(k);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(posedge clk); @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rx(input int unsigned k, input logic [3:0] idx);
      at_edge(k);
      rx_evt = 1'b1; rx_idx = idx;
      @(posedge clk); @(negedge clk);
      rx_evt = 1'b0;
   endtask

   task automatic set_sel(input int unsigned k, input logic [1:0] v);
      at_edge(k);
      ps_sel = v;
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      checks++;
      if (host_rvalid !== 1'b0 || host_rdata !== 8'h00) begin
         failures++;
         $display("FAIL R1 read port in reset actual=%b/%h expected=0/00", host_rvalid, host_rdata);
      end
      rst_n = 1'b1;
      // Reset state (R1)
      rd(1, A_TLO, 8'h00, "R1 timer low after reset");
      rd(2, A_THI, 8'h00, "R1 timer high after reset");
      rd(3, A_STAT, 8'h00, "R1 flag after reset");
      rd(4, A_ST + 5'd6, 8'h00, "R1 stamp3 after reset");
      // Divide by 32: steps at edges 32, 64, 96 (R2, R3)
      rd(40, A_TLO, 8'h01, "R2 one step after 32 clocks");
      rd(97, A_TLO, 8'h03, "R3 div32 three steps");
      // Select change restarts divider, divide by 64 (R8, R3)
      set_sel(100, 2'd1);
      rd(163, A_TLO, 8'h03, "R8 no step before full new period");
      rd(165, A_TLO, 8'h04, "R3 div64 step at restart+64");
      // Divide by 256 (R3)
      set_sel(200, 2'd3);
      rd(455, A_TLO, 8'h04, "R3 div256 before step");
      rd(457, A_TLO, 8'h05, "R3 div256 step");
      // Divide by 128, steps at 588, 716, 844, 972, 1100
      set_sel(460, 2'd2);
      wr(470, A_TLO, 8'hFE);
      wr(471, A_THI, 8'hFF);
      rd(480, A_TLO, 8'hFE, "R4 low byte write");
      rd(481, A_THI, 8'hFF, "R4 high byte write");
      rd(482, A_STAT, 8'h00, "R7 write sets no flag");
      rd(600, A_STAT, 8'h00, "R5 no flag at 0xFFFF");
      rd(601, A_TLO, 8'hFF, "R3 div128 step");
      rd(720, A_STAT, 8'h01, "R5 wrap sets flag");
      rd(721, A_TLO, 8'h00, "R5 wrapped to zero");
      wr(725, A_STAT, 8'h00);
      rd(726, A_STAT, 8'h01, "R6 write of 0 keeps flag");
      wr(730, A_STAT, 8'h01);
      rd(731, A_STAT, 8'h00, "R6 write of 1 clears flag");
      // Write on the step edge 844 (R7)
      wr(844, A_TLO, 8'h55);
      rd(845, A_TLO, 8'h55, "R7 write wins over step");
      rd(846, A_THI, 8'h00, "R4 other byte kept");
      wr(850, A_THI, 8'hFF);
      wr(851, A_TLO, 8'hFF);
      wr(852, A_TLO, 8'h00);
      wr(853, A_THI, 8'h00);
      rd(854, A_STAT, 8'h00, "R7 writes 0xFFFF to 0 set no flag");
      // Clear on the wrap edge 972 (R6)
      wr(900, A_TLO, 8'hFF);
      wr(901, A_THI, 8'hFF);
      wr(972, A_STAT, 8'h01);
      rd(973, A_STAT, 8'h01, "R6 wrap beats same-cycle clear");
      wr(980, A_STAT, 8'h01);
      rd(981, A_STAT, 8'h00, "R6 clear after wrap");
      // Captures (R9, R10, R11, R12)
      wr(1000, A_TLO, 8'h34);
      wr(1001, A_THI, 8'h12);
      rx(1010, 4'd5);
      rd(1011, A_ST + 5'd10, 8'h34, "R9 stamp5 low");
      rd(1012, A_ST + 5'd11, 8'h12, "R9 stamp5 high");
      rx(1100, 4'd0);
      rd(1101, A_ST + 5'd0, 8'h34, "R10 capture takes pre-step value");
      rd(1102, A_TLO, 8'h35, "R10 step still taken");
      rx(1110, 4'd9);
      rd(1111, A_ST + 5'd2, 8'h00, "R11 index 9 leaves stamp1 low");
      rd(1112, A_ST + 5'd3, 8'h00, "R11 index 9 leaves stamp1 high");
      rx(1113, 4'd15);
      rd(1114, A_ST + 5'd14, 8'h00, "R11 index 15 leaves stamp7");
      rd(1115, A_ST + 5'd10, 8'h34, "R12 stamp5 holds");
      rx(1120, 4'd5);
      rd(1121, A_ST + 5'd10, 8'h35, "R12 stamp5 reloads on own index");
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         failures++;
         $display("FAIL R13 missing read data actual=%0d expected=0", exp_q.size());
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule